// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives three channels of complementary pulse-width modulation from one triangle carrier. Each channel has a positive and a negative output. An up/down counter advances on a count clock, which is the base clock divided by a power of two. The counter climbs from zero to a programmable peak and then falls back to zero. Each channel has two thresholds: one is compared against the carrier on the rising slope and the other on the falling slope. The result of these comparisons is the raw positive-phase level, and its complement is the raw negative-phase level.

Every output then passes through a dead-time stage clocked by the undivided base clock. This stage holds back each inactive-to-active transition. A raw pulse no longer than the dead time therefore never reaches the pin.

Peak and threshold writes are buffered and take effect only at the bottom of the carrier. Each pin has its own output-enable. The enable stays low until the control mode is switched on. Between that point and the start of counting, the pins drive fixed idle levels, and those levels differ between the two phases.

Top module: `pwm3_top`

## Requirements
- R1: After reset every bit of `pwm_oe` is 0 (all six pins high impedance).
- R2: With `ctrl_en`=1 and `start`=0, all enables are 1. Positive pins (even indices 0, 2, 4) drive their inactive level and negative pins (odd indices 1, 3, 5) drive their active level.
- R3: While running, one carrier period lasts 2 × `peak_in` × 2^`presc_sel` base-clock cycles.
- R4: The positive pin of channel c is active for ((P − U) + (P − D)) × 2^S − (`dead_in` + 1) base cycles per period. Here P is the peak, U is `cmp_up_in[c*16 +: 16]`, D is `cmp_dn_in[c*16 +: 16]` and S is `presc_sel`.
- R5: The negative pin of channel c is active for (U + D) × 2^S − (`dead_in` + 1) base cycles per period.
- R6: If the width given by R4 or R5 is zero or negative, that pin stays at its inactive level for the whole period.
- R7: While running, the positive and negative pins of a channel are never active in the same cycle.
- R8: Peak and threshold values written while running are adopted only at the carrier bottom. Once adopted, the widths follow R4 and R5 for the new values.
- R9: `active_high`=0 (the reset default) makes a pin's active level low. `active_high`=1 makes it high.
- R10: Clearing `start` returns the pins to the R2 idle levels. Clearing `ctrl_en` drives every bit of `pwm_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Control mode enable; releases the pins from high impedance |
| start | input | 1 | Runs the carrier while high |
| active_high | input | 1 | Polarity select: 1 = active high, 0 = active low |
| presc_sel | input | 3 | Count clock = base clock / 2^presc_sel |
| peak_in | input | 16 | Carrier peak value (buffered) |
| cmp_up_in | input | 48 | Rising-slope thresholds, 16 bits per channel (buffered) |
| cmp_dn_in | input | 48 | Falling-slope thresholds, 16 bits per channel (buffered) |
| dead_in | input | 8 | Dead time in base cycles, minus one |
| pwm_out | output | 6 | Pin levels; even index positive phase, odd index negative |
| pwm_oe | output | 6 | Per-pin output enable |

## Verification
The hardest states to reach are the edges of the pulse-width formula. One is a pulse whose width comes out zero or negative, where the dead time swallows the whole raw pulse. The other is a threshold and peak update that lands in the middle of a running period. The bench steers into the first with directed settings whose raw width equals or falls short of the dead time plus one. It reaches the second by rewriting every buffered value while the carrier runs and measuring only after several periods. Beyond those, seeded random configurations vary the prescaler, peak, thresholds, dead time and polarity. Each pin's active cycles are counted over a window exactly one period long.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_IDLE = 2'd1,
    PM_RUN  = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/pwm3_prescaler.sv
module pwm3_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] mask;

  assign mask = (DIV_W'(1) << sel) - DIV_W'(1);
  assign tick = run && ((div & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) div <= '0;
    else             div <= div + DIV_W'(1);
  end

  // R3
  tick_space_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/pwm3_carrier.sv
module pwm3_carrier #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             peak_in,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cu_in,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cd_in,
  output logic [NUM_CH-1:0]            raw_pos
);
  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             pk_s;
  logic [NUM_CH-1:0][CNT_W-1:0] cu_s;
  logic [NUM_CH-1:0][CNT_W-1:0] cd_s;
  logic                         up;
  logic                         at_top;
  logic                         at_bottom;

  assign at_top    = (cnt == pk_s - CNT_W'(1));
  assign at_bottom = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      up   <= 1'b1;
      pk_s <= '0;
      cu_s <= '0;
      cd_s <= '0;
    end else if (!run) begin
      cnt  <= '0;
      up   <= 1'b1;
      pk_s <= peak_in;
      cu_s <= cu_in;
      cd_s <= cd_in;
    end else if (tick && pk_s != '0) begin
      if (up) begin
        cnt <= cnt + CNT_W'(1);
        if (at_top) up <= 1'b0;
      end else begin
        cnt <= cnt - CNT_W'(1);
        if (at_bottom) begin
          up   <= 1'b1;
          pk_s <= peak_in;
          cu_s <= cu_in;
          cd_s <= cd_in;
        end
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign raw_pos[ch] = up ? (cnt >= cu_s[ch]) : (cnt > cd_s[ch]);
  end

  // R3
  cnt_le_peak_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= pk_s);
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !(tick && !up && cnt == CNT_W'(1)))
      |=> (!run || $stable({pk_s, cu_s, cd_s})));
endmodule

// File: rtl/pwm3_deadtime.sv
module pwm3_deadtime
  import pwm3_pkg::*;
#(
  parameter int DT_W     = 8,
  parameter bit IDLE_ACT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  pin_mode_e       mode,
  input  logic            active_high,
  input  logic [DT_W-1:0] dead,
  input  logic            raw,
  output logic            pin,
  output logic            oe,
  output logic            act
);
  localparam int HW = DT_W + 1;

  logic [HW-1:0] hold;
  logic [HW-1:0] lim;

  assign lim = {1'b0, dead} + HW'(1);

  always_ff @(posedge clk) begin
    if (rst || mode != PM_RUN || !raw) begin
      hold <= '0;
      act  <= 1'b0;
    end else begin
      if (hold != lim) hold <= hold + HW'(1);
      act <= (hold == lim);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
      oe  <= 1'b0;
    end else begin
      unique case (mode)
        PM_IDLE: begin
          oe  <= 1'b1;
          pin <= IDLE_ACT ~^ active_high;
        end
        PM_RUN: begin
          oe  <= 1'b1;
          pin <= act ~^ active_high;
        end
        default: begin
          oe  <= 1'b0;
          pin <= 1'b0;
        end
      endcase
    end
  end

  // R7
  act_raw_chk: assert property (@(posedge clk) disable iff (rst)
    act |-> $past(raw));
  // R4
  dt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> ($past(hold) == ({1'b0, $past(dead)} + HW'(1))));
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
  import pwm3_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  parameter int PRE_W  = 3,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ctrl_en,
  input  logic                    start,
  input  logic                    active_high,
  input  logic [PRE_W-1:0]        presc_sel,
  input  logic [CNT_W-1:0]        peak_in,
  input  logic [NUM_CH*CNT_W-1:0] cmp_up_in,
  input  logic [NUM_CH*CNT_W-1:0] cmp_dn_in,
  input  logic [DT_W-1:0]         dead_in,
  output logic [2*NUM_CH-1:0]     pwm_out,
  output logic [2*NUM_CH-1:0]     pwm_oe
);
  localparam int NUM_PIN = 2 * NUM_CH;

  pin_mode_e           mode_q;
  logic                tick;
  logic [NUM_CH-1:0]   raw_pos;
  logic [NUM_PIN-1:0]  act;
  logic                running;

  always_ff @(posedge clk) begin
    if (rst || !ctrl_en) mode_q <= PM_OFF;
    else if (!start)     mode_q <= PM_IDLE;
    else                 mode_q <= PM_RUN;
  end

  assign running = (mode_q == PM_RUN);

  pwm3_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (running),
    .sel  (presc_sel),
    .tick (tick)
  );

  pwm3_carrier #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_car (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .tick    (tick),
    .peak_in (peak_in),
    .cu_in   (cmp_up_in),
    .cd_in   (cmp_dn_in),
    .raw_pos (raw_pos)
  );

  for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
    logic raw_i;
    if (i % 2 == 0) begin : g_pos
      assign raw_i = raw_pos[i/2];
    end else begin : g_neg
      assign raw_i = ~raw_pos[i/2];
    end
    pwm3_deadtime #(.DT_W(DT_W), .IDLE_ACT(i % 2 == 1)) u_dt (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode_q),
      .active_high (active_high),
      .dead        (dead_in),
      .raw         (raw_i),
      .pin         (pwm_out[i]),
      .oe          (pwm_oe[i]),
      .act         (act[i])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
    // R7
    pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(act[2*c] && act[2*c+1]));
  end

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_OFF) |=> (pwm_oe == '0));
endmodule

// File: tb/tb_pwm3_top.sv
`timescale 1ns/1ps
module tb_pwm3_top;
  localparam int CW = 16;
  localparam int DW = 8;
  localparam int PW = 3;
  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          ctrl_en;
  logic          start;
  logic          active_high;
  logic [PW-1:0] presc_sel;
  logic [CW-1:0] peak_in;
  logic [NC*CW-1:0] cmp_up_in;
  logic [NC*CW-1:0] cmp_dn_in;
  logic [DW-1:0] dead_in;
  logic [2*NC-1:0] pwm_out;
  logic [2*NC-1:0] pwm_oe;

  int checks = 0;
  int errors = 0;

  int c_sel, c_pk, c_dead, c_pol;
  int c_cu[NC];
  int c_cd[NC];

  always #2.5 clk = ~clk;

  pwm3_top dut (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .start(start),
    .active_high(active_high), .presc_sel(presc_sel), .peak_in(peak_in),
    .cmp_up_in(cmp_up_in), .cmp_dn_in(cmp_dn_in), .dead_in(dead_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actv, expv);
    end
  endtask

  function automatic int expw(input int ticks, input int sel, input int dly);
    int w;
    w = ticks * (1 << sel) - (dly + 1);
    return (w > 0) ? w : 0;
  endfunction

  function automatic int period_len();
    return 2 * c_pk * (1 << c_sel);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_cfg();
    @(negedge clk);
    presc_sel   = PW'(c_sel);
    peak_in     = CW'(c_pk);
    dead_in     = DW'(c_dead);
    active_high = c_pol[0];
    for (int ch = 0; ch < NC; ch++) begin
      cmp_up_in[ch*CW +: CW] = CW'(c_cu[ch]);
      cmp_dn_in[ch*CW +: CW] = CW'(c_cd[ch]);
    end
  endtask

  task automatic check_idle(input string req);
    logic [5:0] expv;
    expv = c_pol[0] ? 6'b101010 : 6'b010101;
    chk(pwm_oe == 6'h3f, req, "idle enables", int'(pwm_oe), 63);
    chk(pwm_out == expv, req, "idle levels (R9 polarity)", int'(pwm_out), int'(expv));
  endtask

  task automatic measure(input string tag);
    int p;
    int cnt_act[2*NC];
    int both[NC];
    int ep, en;
    p = period_len();
    for (int i = 0; i < 2*NC; i++) cnt_act[i] = 0;
    for (int ch = 0; ch < NC; ch++) both[ch] = 0;
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2*NC; i++)
        if (pwm_oe[i] && pwm_out[i] == c_pol[0]) cnt_act[i]++;
      for (int ch = 0; ch < NC; ch++)
        if (pwm_out[2*ch] == c_pol[0] && pwm_out[2*ch+1] == c_pol[0]) both[ch]++;
    end
    for (int ch = 0; ch < NC; ch++) begin
      ep = expw((c_pk - c_cu[ch]) + (c_pk - c_cd[ch]), c_sel, c_dead);
      en = expw(c_cu[ch] + c_cd[ch], c_sel, c_dead);
      chk(cnt_act[2*ch] == ep, (ep == 0) ? "R6" : "R4",
          $sformatf("%s ch%0d positive width pol=%0d (R9)", tag, ch, c_pol),
          cnt_act[2*ch], ep);
      chk(cnt_act[2*ch+1] == en, (en == 0) ? "R6" : "R5",
          $sformatf("%s ch%0d negative width pol=%0d (R9)", tag, ch, c_pol),
          cnt_act[2*ch+1], en);
      chk(both[ch] == 0, "R7", $sformatf("%s ch%0d overlap", tag, ch), both[ch], 0);
    end
  endtask

  task automatic period_check(input string tag);
    int p, idx, n;
    bit prev, cur, found;
    p = period_len();
    idx = -1;
    if (expw((c_pk - c_cu[0]) + (c_pk - c_cd[0]), c_sel, c_dead) > 0) idx = 0;
    else if (expw(c_cu[0] + c_cd[0], c_sel, c_dead) > 0) idx = 1;
    if (idx < 0) return;
    found = 0;
    @(negedge clk);
    prev = (pwm_out[idx] == c_pol[0]);
    for (int k = 0; k < 4*p && !found; k++) begin
      @(negedge clk);
      cur = (pwm_out[idx] == c_pol[0]);
      if (cur && !prev) found = 1;
      prev = cur;
    end
    n = 0;
    if (found) begin
      found = 0;
      for (int k = 0; k < 4*p && !found; k++) begin
        @(negedge clk);
        n++;
        cur = (pwm_out[idx] == c_pol[0]);
        if (cur && !prev) found = 1;
        prev = cur;
      end
    end
    chk(found && n == p, "R3", $sformatf("%s period", tag), n, p);
  endtask

  task automatic run_case(input string tag);
    start = 1'b0;
    wait_cyc(4);
    apply_cfg();
    start = 1'b1;
    wait_cyc(3 * period_len() + 20);
    measure(tag);
    period_check(tag);
  endtask

  task automatic rand_cfg();
    c_sel  = $urandom_range(0, 2);
    c_pk   = $urandom_range(4, 20);
    c_dead = $urandom_range(0, 20);
    c_pol  = $urandom_range(0, 1);
    for (int ch = 0; ch < NC; ch++) begin
      c_cu[ch] = $urandom_range(1, c_pk - 1);
      c_cd[ch] = $urandom_range(0, c_pk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int old_p;
    void'($urandom(32'd7041));
    rst = 1'b1; ctrl_en = 1'b0; start = 1'b0; active_high = 1'b0;
    presc_sel = '0; peak_in = '0; cmp_up_in = '0; cmp_dn_in = '0; dead_in = '0;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(3);
    // R1
    chk(pwm_oe == 6'h00, "R1", "enables after reset", int'(pwm_oe), 0);

    // R2 / R9 idle levels, both polarities
    c_pol = 0;
    ctrl_en = 1'b1;
    wait_cyc(4);
    check_idle("R2");
    c_pol = 1;
    active_high = 1'b1;
    wait_cyc(4);
    check_idle("R9");

    // directed: positive raw one cycle, dead time swallows it (R6)
    c_sel = 0; c_pk = 4; c_dead = 0; c_pol = 0;
    for (int ch = 0; ch < NC; ch++) begin c_cu[ch] = 3; c_cd[ch] = 4; end
    c_cu[1] = 1; c_cd[1] = 1;
    run_case("zero-width pos");

    // directed: dead time longer than both raw pulses (R6)
    c_sel = 0; c_pk = 5; c_dead = 10; c_pol = 1;
    for (int ch = 0; ch < NC; ch++) begin c_cu[ch] = 2; c_cd[ch] = 2; end
    run_case("both collapsed");

    // directed: prescaler and high polarity
    c_sel = 2; c_pk = 6; c_dead = 3; c_pol = 1;
    c_cu[0] = 1; c_cd[0] = 0; c_cu[1] = 5; c_cd[1] = 6; c_cu[2] = 3; c_cd[2] = 2;
    run_case("prescaled");

    for (int n = 0; n < 8; n++) begin
      rand_cfg();
      run_case($sformatf("random%0d", n));
    end

    // R8: rewrite buffered values while running
    c_sel = 1; c_pk = 8; c_dead = 2; c_pol = 0;
    for (int ch = 0; ch < NC; ch++) begin c_cu[ch] = 2 + ch; c_cd[ch] = 5 - ch; end
    run_case("R8 before");
    old_p = period_len();
    c_pk = 12;
    for (int ch = 0; ch < NC; ch++) begin c_cu[ch] = 9 - ch; c_cd[ch] = 1 + 2*ch; end
    apply_cfg();
    wait_cyc(3 * (old_p > period_len() ? old_p : period_len()) + 20);
    measure("R8 after update");
    period_check("R8 after update");

    // R10: stop returns idle levels, disable releases pins
    start = 1'b0;
    wait_cyc(4);
    check_idle("R10");
    ctrl_en = 1'b0;
    wait_cyc(4);
    chk(pwm_oe == 6'h00, "R10", "enables after disable", int'(pwm_oe), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule